// File: doc/BRIEF.md
# Split-Field Dictionary Sub-Instruction Decoder

This block rebuilds a 32-bit configuration word for one functional unit from fixed 20-bit compressed codewords. The upper part of a configuration word changes slowly over a program, while the low part changes often. The block therefore sends only the upper 21 bits through a small dictionary, which has eight entries for each unit group. The low 11 bits ride in every codeword as a literal. When the needed upper bits are not in the dictionary, the codeword sets its linked flag. The following codeword then carries 18 of the upper bits, and the three index bits of the first codeword supply the other three. Any value can therefore be encoded and the dictionary can never overflow.

Before a program runs, the dictionaries are filled through a write port while load mode is held high. During execution the fetch logic presents each codeword together with the codeword that follows it. The block returns the rebuilt word, its group identifier and a valid flag one clock later. A linked codeword with a missing or mistagged partner, or a codeword naming a group that does not exist, raises an error flag instead of valid.

Top module: `sfd_decoder`

## Requirements
- R1: While reset is low, and after it is released, out_valid, out_err, out_word and out_group are zero and every dictionary entry of every group reads as zero.
- R2: Codeword layout: bits [19:15] hold the group identifier, bit 14 the linked flag, bits [13:11] the index field and bits [10:0] the literal. A follow-on codeword carries the tag 2'b10 in bits [19:18] and upper bits in [17:0]. Output bits [31:11] are the upper part and bits [10:0] the literal.
- R3: For an accepted codeword with linked flag 0 and a valid group, the next cycle shows out_valid=1 and out_word = {dictionary[group][index], literal}. The follow-on input has no effect.
- R4: For an accepted codeword with linked flag 1 whose partner is valid and tagged 2'b10, the next cycle shows out_valid=1 and out_word = {partner[17:0], index field, literal}. The dictionary is not consulted.
- R5: A linked codeword whose partner is not valid, or whose partner tag is not 2'b10, gives out_err=1 and out_valid=0 in the next cycle.
- R6: A codeword whose group identifier is not below GROUPS (default 4) gives out_err=1 and out_valid=0 in the next cycle, whatever its linked flag.
- R7: While load_mode and ld_we are high, ld_data is written to entry [ld_group][ld_idx] at the clock edge. Codewords presented while load_mode is high produce neither out_valid nor out_err.
- R8: ld_we with load_mode low writes nothing. A write with ld_group not below GROUPS changes no entry.
- R9: For every accepted codeword, whether it decodes or faults, out_group shows its group identifier in the next cycle.
- R10: In a cycle with cw_valid low, the next cycle shows out_valid=0 and out_err=0, and out_word keeps its previous value.
- R11: out_valid and out_err are never high together.
- R12: Codewords presented on consecutive cycles each give their own result one cycle later, with no idle cycle between them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| load_mode | input | 1 | Dictionary fill phase; decoding is suspended |
| ld_we | input | 1 | Dictionary write strobe |
| ld_group | input | 5 | Group selected for the write |
| ld_idx | input | 3 | Entry selected for the write |
| ld_data | input | 21 | Upper-bit value to store |
| cw_valid | input | 1 | A codeword is presented this cycle |
| cw_word | input | 20 | Codeword being decoded |
| nxt_valid | input | 1 | Follow-on codeword is present |
| nxt_word | input | 20 | Follow-on codeword paired with cw_word |
| out_valid | output | 1 | out_word holds a rebuilt configuration word |
| out_err | output | 1 | Last accepted codeword could not be decoded |
| out_word | output | 32 | Rebuilt configuration word |
| out_group | output | 5 | Group identifier of the last accepted codeword |

## Verification
On every cycle, the bound checker covers the timing and exclusivity rules. These are the one-cycle response, the silence of the outputs when no codeword is taken, the error response to a bad partner or an unknown group, and the exact bit assembly of a linked word. It also checks that the literal passes through and that the group identifier is reported. Two kinds of behaviour need stored state that the checker cannot see from the ports, so only the bench scenarios show them. The first is whether the upper bits of a dictionary word come from the right group and entry. The second covers writes that must be ignored, which are writes outside load mode and writes to a missing group, and the clearing of entries by a reset in the middle of a run.

// File: rtl/sfd_pkg.sv
package sfd_pkg;
   // Default geometry of one decoder lane
   localparam int unsigned SFD_GRP_W  = 5;
   localparam int unsigned SFD_IDX_W  = 3;
   localparam int unsigned SFD_LIT_W  = 11;
   localparam int unsigned SFD_HI_W   = 21;
   localparam int unsigned SFD_TAG_W  = 2;
   localparam int unsigned SFD_GROUPS = 4;

   // Outcome of parsing one codeword pair
   typedef enum logic [1:0] {
      DEC_IDLE  = 2'd0,
      DEC_DICT  = 2'd1,
      DEC_LINK  = 2'd2,
      DEC_FAULT = 2'd3
   } sfd_kind_e;
endpackage

// File: rtl/sfd_dict_bank.sv
module sfd_dict_bank #(
   parameter int unsigned GROUPS = 4,
   parameter int unsigned GRP_W  = 5,
   parameter int unsigned IDX_W  = 3,
   parameter int unsigned HI_W   = 21
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [GRP_W-1:0] wr_grp,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [HI_W-1:0]  wr_data,
   input  logic [GRP_W-1:0] rd_grp,
   input  logic [IDX_W-1:0] rd_idx,
   output logic [HI_W-1:0]  rd_data
);
   localparam int unsigned DEPTH = 1 << IDX_W;

   if (GROUPS == 0 || GROUPS > (1 << GRP_W)) begin : g_bad_groups
      $error("sfd_dict_bank: GROUPS must lie in 1..2**GRP_W");
   end

   logic [HI_W-1:0] grp_rd [GROUPS];

   // One small storage array per group; a write lands only on an exact group match
   for (genvar g = 0; g < GROUPS; g++) begin : g_grp
      logic [HI_W-1:0] mem [DEPTH];
      logic            sel;

      assign sel = wr_en && (wr_grp == GRP_W'(g));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
         end else if (sel) begin
            mem[wr_idx] <= wr_data;
         end
      end

      assign grp_rd[g] = mem[rd_idx];
   end

   // Combinational read; an unknown group reads as zero
   always_comb begin
      rd_data = '0;
      for (int k = 0; k < GROUPS; k++) begin
         if (rd_grp == GRP_W'(k)) rd_data = grp_rd[k];
      end
   end
endmodule

// File: rtl/sfd_cw_parse.sv
module sfd_cw_parse import sfd_pkg::*; #(
   parameter int unsigned          GRP_W   = 5,
   parameter int unsigned          IDX_W   = 3,
   parameter int unsigned          LIT_W   = 11,
   parameter int unsigned          HI_W    = 21,
   parameter int unsigned          TAG_W   = 2,
   parameter int unsigned          GROUPS  = 4,
   parameter logic [TAG_W-1:0]     TAG_VAL = 2'b10
) (
   input  logic                                 load_mode,
   input  logic                                 cw_valid,
   input  logic [GRP_W+IDX_W+LIT_W:0]           cw,
   input  logic                                 nxt_valid,
   input  logic [GRP_W+IDX_W+LIT_W:0]           nxt,
   output sfd_kind_e                            kind,
   output logic [GRP_W-1:0]                     grp,
   output logic [IDX_W-1:0]                     idx,
   output logic [LIT_W-1:0]                     lit,
   output logic [HI_W-IDX_W-1:0]                fol
);
   localparam int unsigned LINK_BIT = LIT_W + IDX_W;
   localparam int unsigned GRP_LO   = LINK_BIT + 1;
   localparam int unsigned CW_W     = GRP_LO + GRP_W;
   localparam int unsigned FOL_W    = HI_W - IDX_W;

   if (HI_W <= IDX_W) begin : g_bad_hi
      $error("sfd_cw_parse: HI_W must exceed IDX_W");
   end
   if (TAG_W + FOL_W != CW_W) begin : g_bad_fol
      $error("sfd_cw_parse: tag plus carried upper bits must fill a codeword");
   end

   logic linked;
   logic grp_ok;
   logic tag_ok;

   assign grp    = cw[CW_W-1:GRP_LO];
   assign linked = cw[LINK_BIT];
   assign idx    = cw[LINK_BIT-1:LIT_W];
   assign lit    = cw[LIT_W-1:0];
   assign fol    = nxt[FOL_W-1:0];
   assign grp_ok = 32'(grp) < GROUPS;
   assign tag_ok = nxt_valid && (nxt[CW_W-1 -: TAG_W] == TAG_VAL);

   always_comb begin
      if (!cw_valid || load_mode) kind = DEC_IDLE;
      else if (!grp_ok)           kind = DEC_FAULT;
      else if (!linked)           kind = DEC_DICT;
      else if (tag_ok)            kind = DEC_LINK;
      else                        kind = DEC_FAULT;
   end
endmodule

// File: rtl/sfd_out_stage.sv
module sfd_out_stage import sfd_pkg::*; #(
   parameter bit          OUT_REG = 1'b1,
   parameter int unsigned WORD_W  = 32,
   parameter int unsigned GRP_W   = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  sfd_kind_e         kind,
   input  logic [WORD_W-1:0] word,
   input  logic [GRP_W-1:0]  grp,
   output logic              out_valid,
   output logic              out_err,
   output logic [WORD_W-1:0] out_word,
   output logic [GRP_W-1:0]  out_group
);
   logic hit;
   logic fault;

   assign hit   = (kind == DEC_DICT) || (kind == DEC_LINK);
   assign fault = (kind == DEC_FAULT);

   if (OUT_REG) begin : g_reg
      // Registered result; the word only moves on a good decode
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            out_valid <= 1'b0;
            out_err   <= 1'b0;
            out_word  <= '0;
            out_group <= '0;
         end else begin
            out_valid <= hit;
            out_err   <= fault;
            if (hit)          out_word  <= word;
            if (hit || fault) out_group <= grp;
         end
      end
   end else begin : g_comb
      assign out_valid = hit;
      assign out_err   = fault;
      assign out_word  = hit ? word : '0;
      assign out_group = (hit || fault) ? grp : '0;
   end
endmodule

// File: rtl/sfd_decoder.sv
module sfd_decoder import sfd_pkg::*; #(
   parameter int unsigned      GRP_W   = SFD_GRP_W,
   parameter int unsigned      IDX_W   = SFD_IDX_W,
   parameter int unsigned      LIT_W   = SFD_LIT_W,
   parameter int unsigned      HI_W    = SFD_HI_W,
   parameter int unsigned      TAG_W   = SFD_TAG_W,
   parameter int unsigned      GROUPS  = SFD_GROUPS,
   parameter logic [TAG_W-1:0] TAG_VAL = 2'b10,
   parameter bit               OUT_REG = 1'b1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        load_mode,
   input  logic                        ld_we,
   input  logic [GRP_W-1:0]            ld_group,
   input  logic [IDX_W-1:0]            ld_idx,
   input  logic [HI_W-1:0]             ld_data,
   input  logic                        cw_valid,
   input  logic [GRP_W+IDX_W+LIT_W:0]  cw_word,
   input  logic                        nxt_valid,
   input  logic [GRP_W+IDX_W+LIT_W:0]  nxt_word,
   output logic                        out_valid,
   output logic                        out_err,
   output logic [HI_W+LIT_W-1:0]       out_word,
   output logic [GRP_W-1:0]            out_group
);
   localparam int unsigned WORD_W = HI_W + LIT_W;
   localparam int unsigned FOL_W  = HI_W - IDX_W;

   if (GRP_W == 0 || IDX_W == 0 || LIT_W == 0) begin : g_bad_fields
      $error("sfd_decoder: every codeword field needs at least one bit");
   end

   sfd_kind_e         kind;
   logic [GRP_W-1:0]  grp;
   logic [IDX_W-1:0]  idx;
   logic [LIT_W-1:0]  lit;
   logic [FOL_W-1:0]  fol;
   logic [HI_W-1:0]   dict_hi;
   logic [WORD_W-1:0] word;
   logic              wr_en;

   assign wr_en = load_mode && ld_we;

   sfd_cw_parse #(
      .GRP_W(GRP_W), .IDX_W(IDX_W), .LIT_W(LIT_W), .HI_W(HI_W),
      .TAG_W(TAG_W), .GROUPS(GROUPS), .TAG_VAL(TAG_VAL)
   ) u_parse (
      .load_mode(load_mode),
      .cw_valid (cw_valid),
      .cw       (cw_word),
      .nxt_valid(nxt_valid),
      .nxt      (nxt_word),
      .kind     (kind),
      .grp      (grp),
      .idx      (idx),
      .lit      (lit),
      .fol      (fol)
   );

   sfd_dict_bank #(
      .GROUPS(GROUPS), .GRP_W(GRP_W), .IDX_W(IDX_W), .HI_W(HI_W)
   ) u_dict (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (wr_en),
      .wr_grp (ld_group),
      .wr_idx (ld_idx),
      .wr_data(ld_data),
      .rd_grp (grp),
      .rd_idx (idx),
      .rd_data(dict_hi)
   );

   // Upper bits come either from the dictionary or from the linked pair
   always_comb begin
      if (kind == DEC_LINK) word = {fol, idx, lit};
      else                  word = {dict_hi, lit};
   end

   sfd_out_stage #(
      .OUT_REG(OUT_REG), .WORD_W(WORD_W), .GRP_W(GRP_W)
   ) u_out (
      .clk      (clk),
      .rst_n    (rst_n),
      .kind     (kind),
      .word     (word),
      .grp      (grp),
      .out_valid(out_valid),
      .out_err  (out_err),
      .out_word (out_word),
      .out_group(out_group)
   );
endmodule

// File: rtl/sfd_decoder_chk.sv
module sfd_decoder_chk #(
   parameter int unsigned      GRP_W   = 5,
   parameter int unsigned      IDX_W   = 3,
   parameter int unsigned      LIT_W   = 11,
   parameter int unsigned      HI_W    = 21,
   parameter int unsigned      TAG_W   = 2,
   parameter int unsigned      GROUPS  = 4,
   parameter logic [TAG_W-1:0] TAG_VAL = 2'b10,
   parameter bit               OUT_REG = 1'b1
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic                        load_mode,
   input logic                        cw_valid,
   input logic [GRP_W+IDX_W+LIT_W:0]  cw_word,
   input logic                        nxt_valid,
   input logic [GRP_W+IDX_W+LIT_W:0]  nxt_word,
   input logic                        out_valid,
   input logic                        out_err,
   input logic [HI_W+LIT_W-1:0]       out_word,
   input logic [GRP_W-1:0]            out_group
);
   localparam int unsigned LINK_BIT = LIT_W + IDX_W;
   localparam int unsigned GRP_LO   = LINK_BIT + 1;
   localparam int unsigned CW_W     = GRP_LO + GRP_W;
   localparam int unsigned FOL_W    = HI_W - IDX_W;

   logic take, linked, grp_ok, tag_ok;

   assign take   = cw_valid && !load_mode;
   assign linked = cw_word[LINK_BIT];
   assign grp_ok = 32'(cw_word[CW_W-1:GRP_LO]) < GROUPS;
   assign tag_ok = nxt_valid && (nxt_word[CW_W-1 -: TAG_W] == TAG_VAL);

   p_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !(out_valid && out_err));

   if (OUT_REG) begin : g_seq
      p_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
         !take |=> (!out_valid && !out_err));

      p_dict_lit_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (take && grp_ok && !linked) |=>
            (out_valid && out_word[LIT_W-1:0] == $past(cw_word[LIT_W-1:0])));

      p_link_word_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (take && grp_ok && linked && tag_ok) |=>
            (out_valid && out_word == {$past(nxt_word[FOL_W-1:0]),
                                       $past(cw_word[LINK_BIT-1:0])}));

      p_bad_link_r5: assert property (@(posedge clk) disable iff (!rst_n)
         (take && grp_ok && linked && !tag_ok) |=> (out_err && !out_valid));

      p_bad_group_r6: assert property (@(posedge clk) disable iff (!rst_n)
         (take && !grp_ok) |=> (out_err && !out_valid));

      p_group_echo_r9: assert property (@(posedge clk) disable iff (!rst_n)
         take |=> (out_group == $past(cw_word[CW_W-1:GRP_LO])));
   end
endmodule

bind sfd_decoder sfd_decoder_chk #(
   .GRP_W(GRP_W), .IDX_W(IDX_W), .LIT_W(LIT_W), .HI_W(HI_W),
   .TAG_W(TAG_W), .GROUPS(GROUPS), .TAG_VAL(TAG_VAL), .OUT_REG(OUT_REG)
) u_sfd_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .load_mode(load_mode),
   .cw_valid (cw_valid),
   .cw_word  (cw_word),
   .nxt_valid(nxt_valid),
   .nxt_word (nxt_word),
   .out_valid(out_valid),
   .out_err  (out_err),
   .out_word (out_word),
   .out_group(out_group)
);

// File: tb/test_sfd_decoder.sv
module test_sfd_decoder;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        load_mode = 1'b0, ld_we = 1'b0;
   logic [4:0]  ld_group = '0;
   logic [2:0]  ld_idx = '0;
   logic [20:0] ld_data = '0;
   logic        cw_valid = 1'b0, nxt_valid = 1'b0;
   logic [19:0] cw_word = '0, nxt_word = '0;
   logic        out_valid, out_err;
   logic [31:0] out_word;
   logic [4:0]  out_group;

   int tests = 0;
   int fails = 0;
   bit done  = 1'b0;

   always #2 clk = ~clk;   // 250 MHz

   sfd_decoder i_sfd_decoder (
      .clk(clk), .rst_n(rst_n), .load_mode(load_mode), .ld_we(ld_we),
      .ld_group(ld_group), .ld_idx(ld_idx), .ld_data(ld_data),
      .cw_valid(cw_valid), .cw_word(cw_word), .nxt_valid(nxt_valid),
      .nxt_word(nxt_word), .out_valid(out_valid), .out_err(out_err),
      .out_word(out_word), .out_group(out_group)
   );

   // Entry: {codeword, partner valid, partner, expect valid, expect error}
   localparam int NV = 12;
   localparam logic [42:0] VEC [NV] = '{
      {5'd0,  1'b0, 3'd2, 11'h155, 1'b0, 20'h00000,          1'b1, 1'b0},
      {5'd1,  1'b0, 3'd7, 11'h7FF, 1'b1, 20'hFFFFF,          1'b1, 1'b0},
      {5'd3,  1'b0, 3'd0, 11'h000, 1'b0, 20'h00000,          1'b1, 1'b0},
      {5'd2,  1'b1, 3'd5, 11'h0AA, 1'b1, {2'b10, 18'h2ABCD}, 1'b1, 1'b0},
      {5'd0,  1'b1, 3'd0, 11'h001, 1'b1, {2'b10, 18'h3FFFF}, 1'b1, 1'b0},
      {5'd1,  1'b1, 3'd3, 11'h123, 1'b0, {2'b10, 18'h11111}, 1'b0, 1'b1},
      {5'd1,  1'b1, 3'd3, 11'h123, 1'b1, {2'b01, 18'h11111}, 1'b0, 1'b1},
      {5'd1,  1'b1, 3'd3, 11'h123, 1'b1, {2'b11, 18'h11111}, 1'b0, 1'b1},
      {5'd1,  1'b1, 3'd3, 11'h123, 1'b1, {2'b00, 18'h11111}, 1'b0, 1'b1},
      {5'd4,  1'b0, 3'd1, 11'h010, 1'b0, 20'h00000,          1'b0, 1'b1},
      {5'd31, 1'b1, 3'd6, 11'h3C3, 1'b1, {2'b10, 18'h00001}, 1'b0, 1'b1},
      {5'd3,  1'b1, 3'd7, 11'h7FF, 1'b1, {2'b10, 18'h00000}, 1'b1, 1'b0}
   };

   // Dictionary contents chosen by the bench
   function automatic logic [20:0] dval(int g, int i);
      return {5'(g + 1), 8'(i * 37), 8'(8'hA5 ^ 8'(i))};
   endfunction

   // Expected word per R2, R3, R4
   function automatic logic [31:0] model(logic [19:0] cw, logic [19:0] nx);
      if (cw[14]) return {nx[17:0], cw[13:0]};
      return {dval(int'(cw[19:15]), int'(cw[13:11])), cw[10:0]};
   endfunction

   task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
      tests++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic step(logic v, logic [19:0] cw, logic nv, logic [19:0] nx);
      @(negedge clk);
      cw_valid  = v;
      cw_word   = cw;
      nxt_valid = nv;
      nxt_word  = nx;
      @(posedge clk);
      #1;
   endtask

   task automatic wr(logic lm, logic we, logic [4:0] g, logic [2:0] i, logic [20:0] d);
      @(negedge clk);
      load_mode = lm;
      ld_we     = we;
      ld_group  = g;
      ld_idx    = i;
      ld_data   = d;
      @(posedge clk);
      #1;
   endtask

   task automatic end_load();
      @(negedge clk);
      load_mode = 1'b0;
      ld_we     = 1'b0;
   endtask

   initial begin
      logic [31:0] held;
      repeat (3) @(posedge clk);
      #1;
      // R1: reset state
      chk("R1 valid in reset", 32'(out_valid), 32'd0);
      chk("R1 err in reset", 32'(out_err), 32'd0);
      chk("R1 word in reset", out_word, 32'd0);
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk);
      #1;
      chk("R1 group after reset", 32'(out_group), 32'd0);

      // R1: dictionary is cleared, so upper bits read as zero
      step(1'b1, {5'd2, 1'b0, 3'd3, 11'h012}, 1'b0, 20'h0);
      chk("R1 cleared entry", out_word, 32'h0000_0012);

      // R7: fill dictionaries while a codeword is also presented
      @(negedge clk);
      cw_valid = 1'b1;
      cw_word  = {5'd0, 1'b0, 3'd1, 11'h001};
      for (int g = 0; g < 4; g++)
         for (int i = 0; i < 8; i++)
            wr(1'b1, 1'b1, 5'(g), 3'(i), dval(g, i));
      chk("R7 no valid in load", 32'(out_valid), 32'd0);
      chk("R7 no err in load", 32'(out_err), 32'd0);
      // R8: write to a missing group (aliases group 0 if truncated)
      wr(1'b1, 1'b1, 5'd4, 3'd0, 21'h0ABCDE);
      end_load();
      // R8: write strobe outside load mode
      wr(1'b0, 1'b1, 5'd0, 3'd1, 21'h155555);
      ld_we = 1'b0;

      step(1'b1, {5'd0, 1'b0, 3'd0, 11'h000}, 1'b0, 20'h0);
      chk("R8 missing group write ignored", out_word, {dval(0, 0), 11'h000});
      step(1'b1, {5'd0, 1'b0, 3'd1, 11'h000}, 1'b0, 20'h0);
      chk("R8 write outside load ignored", out_word, {dval(0, 1), 11'h000});
      step(1'b1, {5'd3, 1'b0, 3'd6, 11'h0F0}, 1'b0, 20'h0);
      chk("R7 entry written", out_word, {dval(3, 6), 11'h0F0});

      // R12: table walked on consecutive cycles
      for (int n = 0; n < NV; n++) begin
         logic [42:0] e;
         e = VEC[n];
         step(1'b1, e[42:23], e[22], e[21:2]);
         chk($sformatf("R12 valid vec %0d", n), 32'(out_valid), 32'(e[1]));
         chk($sformatf("R5/R6 err vec %0d", n), 32'(out_err), 32'(e[0]));
         chk($sformatf("R9 group vec %0d", n), 32'(out_group), 32'(e[42:38]));
         chk($sformatf("R11 exclusive vec %0d", n), 32'(out_valid && out_err), 32'd0);
         if (e[1])
            chk($sformatf("R3/R4 word vec %0d", n), out_word, model(e[42:23], e[21:2]));
      end

      // R10: idle cycle, word held
      step(1'b1, {5'd1, 1'b0, 3'd4, 11'h2A2}, 1'b0, 20'h0);
      held = out_word;
      chk("R3 word before idle", held, {dval(1, 4), 11'h2A2});
      step(1'b0, {5'd2, 1'b1, 3'd1, 11'h111}, 1'b1, {2'b10, 18'h3C3C3});
      chk("R10 valid low", 32'(out_valid), 32'd0);
      chk("R10 err low", 32'(out_err), 32'd0);
      chk("R10 word held", out_word, held);

      // R1: reset in mid-run clears entries
      @(negedge clk);
      rst_n = 1'b0;
      cw_valid = 1'b0;
      @(posedge clk);
      #1;
      chk("R1 valid after mid reset", 32'(out_valid), 32'd0);
      @(negedge clk);
      rst_n = 1'b1;
      step(1'b1, {5'd1, 1'b0, 3'd2, 11'h0C0}, 1'b0, 20'h0);
      chk("R1 entry cleared by reset", out_word, 32'h0000_00C0);
      step(1'b0, 20'h0, 1'b0, 20'h0);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      #200000;
      if (!done) begin
         tests++;
         fails++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end
endmodule